// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Handshake-Cleared Status Flags

This block is one 16-bit timer channel. A free-running counter advances on each clock in which the count-enable input is high. It has six general registers, named A to F. Each one is set up on its own either to hold the counter value when its capture pulse arrives, or to be compared with the counter and raise a one-clock match pulse when the two are equal.

Every event sets a sticky flag in an 8-bit status register: a counter wrap, a capture, or a compare match. Software clears a flag with a two-step handshake. It must first read the status register while the flag is 1, and then write a 0 to that bit. Any new event on a flag cancels a pending handshake, so no event is lost. A 7-bit enable mask picks which flags drive the single interrupt request. Software reaches the counter, the mode register, the status register, the enable mask and the six general registers over a simple strobed register bus. The read data path is combinational.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter, mode register, enable mask, general registers, status flags and pending handshakes are all 0, and `irq` and `cmp_out` are low.
- R2: The counter goes up by 1 on each clock with `cnt_en` high and holds otherwise. A bus write to address 0 loads the counter and takes priority over counting.
- R3: The overflow flag is status bit 6. It sets when an enabled count takes the counter from 0xFFFF to 0x0000.
- R4: Status bit 7 always reads 0, and bits 0 to 5 are the flags of registers A to F. Writing 1 to a status bit never sets a flag. Writing 0 to a flag that has not been read as 1 since its last event leaves it set.
- R5: A read of the status register (address 2, `rd` high) that returns a flag at 1 arms that flag. A later write with 0 in that bit clears it. Any set event disarms the flag, and a set event wins over a clear in the same cycle.
- R6: When mode bit i is 1 (capture), a high `cap_in[i]` copies the current counter into general register i and sets flag i. Bus writes to that register are ignored while it is in capture mode.
- R7: When mode bit i is 0 (compare), a cycle with `cnt_en` high and the counter equal to general register i sets flag i and pulses `cmp_out[i]` high for exactly the next clock. A `cap_in[i]` pulse then has no effect.
- R8: `irq` is high exactly when some status flag is 1 and the enable mask bit at the same position (bit 6 overflow, bits 0 to 5 registers A to F) is 1.
- R9: The address map is: 0 counter, 1 mode, 2 status, 3 enable mask, and 8 to 13 general registers A to F. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational from addr) |
| rd | input | 1 | Read strobe, arms flags read as 1 |
| wr | input | 1 | Write strobe |
| cnt_en | input | 1 | Count enable |
| cap_in | input | 6 | Capture pulses, bit 0 = A |
| cmp_out | output | 6 | One-clock compare match pulses, bit 0 = A |
| irq | output | 1 | Interrupt request |

## Verification
The clearing write to the status register and a new set event on the same flag can fall in one cycle. The bench provokes this by arming flag A with a read, and then driving the zero write and a capture pulse on A in the same clock. The flag must stay at 1. A second zero write without a new read must also leave it set, which the bench observes on `irq` so that no read re-arms the flag. Only a fresh read and write may then clear it.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int CW = 16,
  parameter int NG = 6,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          rd,
  input  logic          wr,
  input  logic          cnt_en,
  input  logic [NG-1:0] cap_in,
  output logic [NG-1:0] cmp_out,
  output logic          irq
);
  localparam int FW = NG + 1;
  localparam logic [AW-1:0] A_CNT  = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_EN   = AW'(3);
  localparam logic [AW-1:0] A_GR0  = AW'(8);

  logic [CW-1:0] cnt;
  logic [NG-1:0] mode;
  logic [FW-1:0] flags, armed, en_r;
  logic [CW-1:0] gr [NG];
  logic [NG-1:0] cap_hit, cmp_hit;

  wire [AW-1:0] gidx  = addr - A_GR0;
  wire          gsel  = (addr >= A_GR0) && (int'(gidx) < NG);
  wire          cnt_wr = wr && addr == A_CNT;
  wire          wrap  = cnt_en && !cnt_wr && (&cnt);
  wire          st_rd = rd && addr == A_STAT;
  wire          st_wr = wr && addr == A_STAT;
  wire [FW-1:0] set_v = {wrap, cap_hit | cmp_hit};
  wire [FW-1:0] clr_v = st_wr ? (armed & ~wdata[FW-1:0]) : '0;

  always_comb
    for (int i = 0; i < NG; i++) begin
      cap_hit[i] = mode[i] && cap_in[i];
      cmp_hit[i] = !mode[i] && cnt_en && cnt == gr[i];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      mode    <= '0;
      en_r    <= '0;
      flags   <= '0;
      armed   <= '0;
      cmp_out <= '0;
    end else begin
      if (cnt_wr)      cnt <= wdata;
      else if (cnt_en) cnt <= cnt + 1'b1;
      if (wr && addr == A_MODE) mode <= wdata[NG-1:0];
      if (wr && addr == A_EN)   en_r <= wdata[FW-1:0];
      flags   <= (flags & ~clr_v) | set_v;
      armed   <= (armed | (st_rd ? flags : '0)) & ~clr_v & ~set_v;
      cmp_out <= cmp_hit;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NG; i++) gr[i] <= '0;
    end else begin
      for (int i = 0; i < NG; i++)
        if (cap_hit[i]) gr[i] <= cnt;
        else if (wr && gsel && int'(gidx) == i && !mode[i]) gr[i] <= wdata;
    end

  assign irq = |(flags & en_r);

  always_comb begin
    rdata = '0;
    if (gsel) rdata = gr[gidx[$clog2(NG)-1:0]];
    else
      case (addr)
        A_CNT:   rdata = cnt;
        A_MODE:  rdata[NG-1:0] = mode;
        A_STAT:  rdata[FW-1:0] = flags;
        A_EN:    rdata[FW-1:0] = en_r;
        default: rdata = '0;
      endcase
  end

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_wr && cnt == {CW{1'b1}}) |=> (flags[NG] && cnt == '0));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_wr) |=> $stable(cnt));

  generate
    for (genvar g = 0; g < NG; g++) begin : g_chk
      // R5
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[g]) |-> $past(st_wr && armed[g] && !wdata[g]));
      // R6
      capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_in[g] && mode[g]) |=> (gr[g] == $past(cnt) && flags[g]));
      // R7
      cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_out[g] |-> (flags[g] && !$past(mode[g])));
    end
  endgenerate
endmodule

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        rd = 0, wr = 0, cnt_en = 0;
  logic [5:0]  cap_in = 0, cmp_out;
  logic        irq;
  int checks = 0, errors = 0;

  capcmp_timer u_capcmp_timer (.clk, .rst_n, .addr, .wdata, .rdata, .rd, .wr,
                               .cnt_en, .cap_in, .cmp_out, .irq);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic run(int n);
    @(negedge clk); cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0;
  endtask

  task automatic pulse_cap(logic [5:0] m);
    @(negedge clk); cap_in = m;
    @(negedge clk); cap_in = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd_reg(0, d); chk("R1 counter", d, 16'h0);
    rd_reg(2, d); chk("R1 status", d, 16'h0);
    rd_reg(10, d); chk("R1 gr C", d, 16'h0);
    chk("R1 irq/cmp_out", {9'b0, irq, cmp_out}, 16'h0);
  endtask

  task automatic t_count();
    logic [15:0] d;
    wr_reg(0, 16'h1234);
    rd_reg(0, d); chk("R2 load", d, 16'h1234);
    run(5);
    rd_reg(0, d); chk("R2 count 5", d, 16'h1239);
  endtask

  task automatic t_overflow();
    logic [15:0] d;
    wr_reg(0, 16'hFFFE);
    run(1);
    rd_reg(2, d); chk("R3 no ovf before wrap", d, 16'h0);
    run(1);
    rd_reg(0, d); chk("R3 counter wrapped", d, 16'h0);
    wr_reg(3, 16'h003F);
    chk("R8 irq masked", {15'b0, irq}, 16'h0);
    wr_reg(3, 16'h0040);
    chk("R8 irq enabled", {15'b0, irq}, 16'h1);
    wr_reg(2, 16'h0000);
    chk("R4 unread zero write keeps flag", {15'b0, irq}, 16'h1);
    rd_reg(2, d); chk("R3 R4 ovf bit6, bit7 zero", d, 16'h0040);
    wr_reg(2, 16'h0000);
    rd_reg(2, d); chk("R5 cleared after read+write0", d, 16'h0);
    wr_reg(2, 16'h00FF);
    rd_reg(2, d); chk("R4 write 1 does not set", d, 16'h0);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    wr_reg(1, 16'h0001);
    wr_reg(0, 16'h0100);
    pulse_cap(6'b000001);
    rd_reg(8, d); chk("R6 capture A value", d, 16'h0100);
    wr_reg(8, 16'hBEEF);
    rd_reg(8, d); chk("R6 bus write ignored in capture", d, 16'h0100);
    wr_reg(1, 16'h0021);
    pulse_cap(6'b100010);
    rd_reg(13, d); chk("R6 R9 capture F value", d, 16'h0100);
    rd_reg(2, d); chk("R6 R7 flags A,F only", d, 16'h0021);
    wr_reg(2, 16'h0000);
    rd_reg(2, d); chk("R5 capture flags cleared", d, 16'h0);
  endtask

  task automatic t_compare();
    logic [15:0] d;
    wr_reg(1, 16'h0000);
    wr_reg(10, 16'h0205);
    rd_reg(10, d); chk("R7 gr C writable", d, 16'h0205);
    wr_reg(0, 16'h0200);
    @(negedge clk); cnt_en = 1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk($sformatf("R7 cmp_out step %0d", k), {10'b0, cmp_out}, (k == 6) ? 16'h0004 : 16'h0);
    end
    cnt_en = 0;
    rd_reg(2, d); chk("R7 compare flag C", d, 16'h0004);
    wr_reg(2, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    wr_reg(1, 16'h0001);
    wr_reg(3, 16'h0001);
    pulse_cap(6'b000001);
    rd_reg(2, d); chk("R5 flag A armed read", d, 16'h0001);
    @(negedge clk); wr = 1; addr = 2; wdata = 0; cap_in = 6'b000001;
    @(negedge clk); wr = 0; cap_in = 0;
    chk("R5 set wins over clear", {15'b0, irq}, 16'h1);
    wr_reg(2, 16'h0000);
    chk("R5 disarmed after set", {15'b0, irq}, 16'h1);
    rd_reg(2, d);
    wr_reg(2, 16'h0000);
    chk("R5 R8 cleared after new read", {15'b0, irq}, 16'h0);
    rd_reg(5, d); chk("R9 unmapped reads 0", d, 16'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_overflow();
    t_capture();
    t_compare();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule